// File: doc/BRIEF.md
# Zero-Vector-Free Space Vector Modulator

This block drives the six gate lines of a two-level three-phase voltage source inverter with space vector modulation that never applies a zero vector. Each carrier period holds only the two active vectors that bound the current 60-degree sector. The first vector takes a share of the period equal to its raw dwell over the sum of both raw dwells, and the second vector fills the rest. As a result, two legs stay clamped for the whole sector and only one leg switches. The dc link is expected to carry the six-times-fundamental envelope that this scheme needs. That envelope, dead time and angle estimation are handled elsewhere.

The reference is given as a sector number and an in-sector angle index. A switching-period length in clock cycles comes with it. The inputs are plain level signals and have no back-pressure. The block samples them only on the cycle that opens a period. A small sequential engine then computes the first-vector dwell during that period, using a sine table and a restoring divider. The result takes effect at the next period boundary, so every pattern lags its inputs by exactly one period. The first period after enabling is a priming period in which all gates are off.

Top module: `svm_zero_vector_mod`

## Requirements
- R1: While reset is low, and from the first clock edge that samples `en` low, every upper and lower gate output is 0, `period_strobe` is 0 and `sector_out` is 0.
- R2: On the first clock edge that samples `en` high after a disabled state, a priming period begins. `period_strobe` is 1 in its first cycle, all gates stay 0 for the whole period, and its length is the clamped `period_in` sampled on that edge.
- R3: A period lasts L cycles, where L is `period_in` raised to a minimum of SIN_W+CNT_W+8 (32 with defaults). `period_strobe` is high in exactly the first cycle of each period.
- R4: Gate bit 0 is phase A, bit 1 is B and bit 2 is C. Vector i drives the upper-gate pattern 001, 011, 010, 110, 100, 101 for i = 0 to 5. Sector s applies vector s first and then vector (s+1) mod 6.
- R5: With N = 2^ANG_W and code(j) = round((2^SIN_W−1)·sin(j·π/(3N))), the first vector lasts floor(code(N−k)·L / (code(N−k)+code(k))) cycles for angle index k, within one cycle. The second vector lasts for the rest of the period.
- R6: While active, the outputs never show the all-off or all-on upper pattern, and at most one leg changes state between two cycles of the same period.
- R7: While active, each lower gate is the complement of its upper gate, and no leg ever has both gates high.
- R8: A sector input of 6 or 7 is handled as sector 0.
- R9: The sector, angle and period inputs affect only the period that follows the one opened by the edge that sampled them. Values present at other times have no effect.
- R10: An angle index of 0 keeps the first vector for the whole period, with no switching.
- R11: While active, `sector_out` shows the sector of the pattern being applied and stays constant within a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; low forces all gates off |
| sector_in | input | 3 | Reference sector, 0 to 5 |
| theta_in | input | ANG_W | Angle index within the sector, 0 to N−1 |
| period_in | input | CNT_W | Carrier period length in clock cycles |
| gate_hi | output | 3 | Upper switch gates, phases A, B, C |
| gate_lo | output | 3 | Lower switch gates, phases A, B, C |
| sector_out | output | 3 | Sector being applied, 0 when inactive |
| period_strobe | output | 1 | High in the first cycle of every period |

## Verification
On a period boundary, a single edge does two things: it hands the finished dwell into the active pattern, and it captures fresh inputs for the next computation. The bench provokes this every time. It rewrites the sector, angle and period inputs right after a boundary, and again right after the following one. It then checks that the measured period still reflects only the earlier values. A second collision is a disable that lands in the middle of a period while the dwell engine is busy. Here the gates must go off on the next cycle, and the re-enable must start a clean priming period.

// File: rtl/svm_pkg.sv
package svm_pkg;

  localparam int NUM_SECTORS = 6;
  localparam int NUM_PHASES  = 3;

  typedef enum logic [2:0] {
    C_IDLE,
    C_RDA,
    C_RDB,
    C_LOAD,
    C_WAIT
  } calc_state_e;

  // Upper gate of phase ph is on in active vector idx.
  function automatic logic vec_phase_on(input int unsigned idx, input int unsigned ph);
    return ((idx + 7 - 2 * ph) % NUM_SECTORS) < 3;
  endfunction

  // Sine code over one sector span, evaluated at elaboration.
  function automatic int sin_code(input int j, input int n, input int w);
    real x, term, acc;
    x    = (3.14159265358979 * j) / (3.0 * n);
    term = x;
    acc  = x;
    for (int i = 1; i < 8; i++) begin
      term = -term * x * x / ((2.0 * i) * (2.0 * i + 1.0));
      acc  = acc + term;
    end
    return $rtoi(acc * (2.0 ** w - 1.0) + 0.5);
  endfunction

endpackage

// File: rtl/svm_sine_rom.sv
module svm_sine_rom #(
  parameter int ANG_W = 6,
  parameter int SIN_W = 12
) (
  input  logic             clk,
  input  logic [ANG_W:0]   addr,
  output logic [SIN_W-1:0] data
);
  localparam int N = 1 << ANG_W;

  logic [SIN_W-1:0] tab [0:N];

  for (genvar j = 0; j <= N; j++) begin : g_ent
    localparam int VAL = svm_pkg::sin_code(j, N, SIN_W);
    assign tab[j] = SIN_W'(VAL);
  end

  logic [ANG_W:0] idx;
  assign idx = (int'(addr) > N) ? '0 : addr;

  always_ff @(posedge clk) begin
    data <= tab[idx];
  end
endmodule

// File: rtl/svm_divider.sv
module svm_divider #(
  parameter int NUM_W = 24,
  parameter int DEN_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             done
);
  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0]  rem_q, den_q;
  logic [NUM_W-1:0]  q_q;
  logic [STEP_W-1:0] step_q;
  logic              busy_q, done_q;
  logic [DEN_W:0]    rem_sh;
  logic              ge;

  assign rem_sh = {rem_q, q_q[NUM_W-1]};
  assign ge     = rem_sh >= {1'b0, den_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      den_q  <= '0;
      q_q    <= '0;
      step_q <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      rem_q  <= '0;
      den_q  <= den;
      q_q    <= num;
      step_q <= STEP_W'(NUM_W);
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      rem_q  <= ge ? DEN_W'(rem_sh - {1'b0, den_q}) : rem_sh[DEN_W-1:0];
      q_q    <= {q_q[NUM_W-2:0], ge};
      step_q <= step_q - 1'b1;
      if (step_q == STEP_W'(1)) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

  assign quo  = q_q;
  assign done = done_q;
endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc #(
  parameter int ANG_W = 6,
  parameter int SIN_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [ANG_W-1:0] theta,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] c1,
  output logic             ready
);
  import svm_pkg::*;

  localparam int N     = 1 << ANG_W;
  localparam int NUM_W = SIN_W + CNT_W;
  localparam int DEN_W = SIN_W + 1;

  calc_state_e      state_q;
  logic [ANG_W-1:0] k_q;
  logic [CNT_W-1:0] len_q, c1_q;
  logic [SIN_W-1:0] s1_q, rom_data;
  logic [ANG_W:0]   rom_addr;
  logic             ready_q, div_go, div_done;
  logic [NUM_W-1:0] div_num, div_quo;
  logic [DEN_W-1:0] div_den;

  assign rom_addr = (state_q == C_RDA) ? (ANG_W+1)'(N) - {1'b0, k_q} : {1'b0, k_q};
  assign div_go   = (state_q == C_LOAD);
  assign div_num  = NUM_W'(s1_q) * NUM_W'(len_q);
  assign div_den  = DEN_W'(s1_q) + DEN_W'(rom_data);

  svm_sine_rom #(.ANG_W(ANG_W), .SIN_W(SIN_W)) u_rom (
    .clk(clk), .addr(rom_addr), .data(rom_data)
  );

  svm_divider #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_go), .num(div_num),
    .den(div_den), .quo(div_quo), .done(div_done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      state_q <= C_IDLE;
      ready_q <= 1'b0;
      k_q     <= '0;
      len_q   <= '0;
      s1_q    <= '0;
      c1_q    <= '0;
    end else if (start) begin
      state_q <= C_RDA;
      ready_q <= 1'b0;
      k_q     <= theta;
      len_q   <= len;
    end else begin
      case (state_q)
        C_RDA:  state_q <= C_RDB;
        C_RDB:  begin s1_q <= rom_data; state_q <= C_LOAD; end
        C_LOAD: state_q <= C_WAIT;
        C_WAIT: if (div_done) begin
                  c1_q    <= CNT_W'(div_quo);
                  ready_q <= 1'b1;
                  state_q <= C_IDLE;
                end
        default: state_q <= C_IDLE;
      endcase
    end
  end

  assign c1    = c1_q;
  assign ready = ready_q;

  // R5: the divider never returns a share longer than the period
  assert_share_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == C_WAIT && div_done) |-> (div_quo <= NUM_W'(len_q)));

  // R3: the dwell computation is finished before the next boundary
  assert_calc_done_by_boundary_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !abort) |-> (state_q == C_IDLE));
endmodule

// File: rtl/svm_gate_decode.sv
module svm_gate_decode (
  input  logic       active,
  input  logic [2:0] sector,
  input  logic       second,
  output logic [2:0] hi,
  output logic [2:0] lo
);
  import svm_pkg::*;

  logic [2:0] nxt, idx;
  assign nxt = (sector == 3'd5) ? 3'd0 : sector + 3'd1;
  assign idx = second ? nxt : sector;

  for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
    logic on;
    assign on    = vec_phase_on(int'(idx), p);
    assign hi[p] = active & on;
    assign lo[p] = active & ~on;
  end
endmodule

// File: rtl/svm_zero_vector_mod.sv
module svm_zero_vector_mod #(
  parameter int ANG_W = 6,
  parameter int SIN_W = 12,
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [2:0]       sector_in,
  input  logic [ANG_W-1:0] theta_in,
  input  logic [CNT_W-1:0] period_in,
  output logic [2:0]       gate_hi,
  output logic [2:0]       gate_lo,
  output logic [2:0]       sector_out,
  output logic             period_strobe
);
  localparam int MIN_LEN = SIN_W + CNT_W + 8;

  logic             run_q, act_ok_q, bound, calc_ready;
  logic [CNT_W-1:0] cnt_q, act_len_q, act_c1_q, pnd_len_q, len_in, calc_c1;
  logic [2:0]       act_sec_q, pnd_sec_q, sec_in;

  assign len_in = (period_in < CNT_W'(MIN_LEN)) ? CNT_W'(MIN_LEN) : period_in;
  assign sec_in = (sector_in > 3'd5) ? 3'd0 : sector_in;
  assign bound  = en && (!run_q || cnt_q == act_len_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      act_ok_q  <= 1'b0;
      cnt_q     <= '0;
      act_len_q <= '0;
      act_c1_q  <= '0;
      act_sec_q <= '0;
      pnd_len_q <= '0;
      pnd_sec_q <= '0;
    end else if (!en) begin
      run_q    <= 1'b0;
      act_ok_q <= 1'b0;
      cnt_q    <= '0;
    end else if (bound) begin
      run_q     <= 1'b1;
      cnt_q     <= '0;
      act_ok_q  <= run_q & calc_ready;
      act_sec_q <= pnd_sec_q;
      act_c1_q  <= calc_c1;
      act_len_q <= run_q ? pnd_len_q : len_in;
      pnd_sec_q <= sec_in;
      pnd_len_q <= len_in;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  svm_dwell_calc #(.ANG_W(ANG_W), .SIN_W(SIN_W), .CNT_W(CNT_W)) u_calc (
    .clk(clk), .rst_n(rst_n), .start(bound), .abort(!en),
    .theta(theta_in), .len(len_in), .c1(calc_c1), .ready(calc_ready)
  );

  svm_gate_decode u_dec (
    .active(act_ok_q), .sector(act_sec_q), .second(cnt_q >= act_c1_q),
    .hi(gate_hi), .lo(gate_lo)
  );

  assign sector_out    = act_ok_q ? act_sec_q : 3'd0;
  assign period_strobe = run_q && (cnt_q == '0);

  assert_gates_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gate_hi == 3'b000 && gate_lo == 3'b000));

  assert_no_zero_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
    act_ok_q |-> (gate_hi != 3'b000 && gate_hi != 3'b111));

  assert_single_leg_moves_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ok_q && !period_strobe) |-> ($countones(gate_hi ^ $past(gate_hi)) <= 1));

  assert_sector_held_in_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !period_strobe) |-> $stable(sector_out));
endmodule

// File: tb/svm_zero_vector_mod_test.sv
module svm_zero_vector_mod_test;
  logic clk = 1'b0;
  logic rst_n, en;
  logic [2:0] sector_in;
  logic [5:0] theta_in;
  logic [11:0] period_in;
  logic [2:0] gate_hi, gate_lo, sector_out;
  logic period_strobe;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  svm_zero_vector_mod uut (
    .clk(clk), .rst_n(rst_n), .en(en), .sector_in(sector_in),
    .theta_in(theta_in), .period_in(period_in), .gate_hi(gate_hi),
    .gate_lo(gate_lo), .sector_out(sector_out), .period_strobe(period_strobe)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int code(input int j);
    return $rtoi(4095.0 * $sin(3.14159265358979 * j / 192.0) + 0.5);
  endfunction

  function automatic int exp_c1(input int k, input int l);
    longint s1, s2;
    s1 = code(64 - k);
    s2 = code(k);
    return int'((s1 * l) / (s1 + s2));
  endfunction

  function automatic logic [2:0] vec_hi(input int i);
    case (i % 6)
      0: return 3'b001;
      1: return 3'b011;
      2: return 3'b010;
      3: return 3'b110;
      4: return 3'b100;
      default: return 3'b101;
    endcase
  endfunction

  function automatic int clampl(input int p);
    return (p < 32) ? 32 : p;
  endfunction

  task automatic wait_strobe();
    do @(negedge clk); while (!period_strobe);
  endtask

  // Called at the negedge of a period's first cycle; measures that period.
  task automatic measure(input int s, input int k, input int l);
    int f = 0, sc = 0, bad = 0, zero = 0, secbad = 0, len = 0;
    bit seen2 = 0;
    do begin
      len++;
      if (gate_hi == 3'b000 || gate_hi == 3'b111) zero++;
      if (gate_hi == vec_hi(s) && gate_lo == ~vec_hi(s) && !seen2) f++;
      else if (gate_hi == vec_hi(s + 1) && gate_lo == ~vec_hi(s + 1)) begin
        sc++;
        seen2 = 1;
      end else bad++;
      if (sector_out != 3'(s)) secbad++;
      @(negedge clk);
    end while (!period_strobe);
    chk(len == l, "R3", "period length", len, l);
    chk(bad == 0, "R4", "cycles off the vector pair", bad, 0);
    chk(bad == 0, "R7", "complement violations", bad, 0);
    chk(zero == 0, "R6", "zero-vector cycles", zero, 0);
    chk(f - exp_c1(k, l) <= 1 && exp_c1(k, l) - f <= 1, "R5", "first-vector cycles",
        f, exp_c1(k, l));
    chk(secbad == 0, "R11", "sector_out mismatches", secbad, 0);
    if (k == 0) chk(sc == 0 && f == l, "R10", "second-vector cycles", sc, 0);
  endtask

  task automatic run_case(input int sd, input int k, input int per, input int s);
    sector_in = 3'(sd);
    theta_in  = 6'(k);
    period_in = 12'(per);
    wait_strobe();
    // R9: disturb inputs; they must not affect the measured period
    sector_in = 3'(sd + 3);
    theta_in  = 6'(k + 17);
    period_in = 12'(per + 13);
    wait_strobe();
    measure(s, k, clampl(per));
  endtask

  initial begin
    int len, on;
    rst_n = 0; en = 0; sector_in = 0; theta_in = 0; period_in = 12'd40;
    repeat (3) begin
      @(negedge clk);
      chk(gate_hi == 0 && gate_lo == 0, "R1", "gates in reset", int'({gate_hi, gate_lo}), 0);
      chk(period_strobe == 0 && sector_out == 0, "R1", "strobe/sector in reset",
          int'({period_strobe, sector_out}), 0);
    end
    rst_n = 1;
    @(negedge clk);
    sector_in = 3'd2; theta_in = 6'd10; period_in = 12'd50; en = 1;
    @(negedge clk);
    chk(period_strobe == 1, "R2", "priming strobe", int'(period_strobe), 1);
    len = 0; on = 0;
    do begin
      len++;
      if (gate_hi != 0 || gate_lo != 0) on++;
      @(negedge clk);
    end while (!period_strobe);
    chk(len == 50, "R2", "priming length", len, 50);
    chk(on == 0, "R2", "priming gate cycles", on, 0);
    measure(2, 10, 50);
    run_case(1, 20, 10, 1);   // R3 clamp to minimum
    for (int k = 0; k < 64; k++) run_case(0, k, 64, 0);
    for (int s = 0; s < 8; s++) begin
      for (int i = 0; i < 6; i++) begin
        for (int p = 0; p < 2; p++) begin
          int kk;
          kk = (i == 0) ? 0 : (i == 1) ? 1 : (i == 2) ? 13 : (i == 3) ? 32 : (i == 4) ? 50 : 63;
          run_case(s, kk, p == 0 ? 40 : 150, s > 5 ? 0 : s);   // R8 for s = 6, 7
        end
      end
    end
    repeat (7) @(negedge clk);
    en = 0;
    repeat (6) begin
      @(negedge clk);
      chk(gate_hi == 0 && gate_lo == 0, "R1", "gates after disable", int'({gate_hi, gate_lo}), 0);
      chk(period_strobe == 0 && sector_out == 0, "R1", "strobe/sector after disable",
          int'({period_strobe, sector_out}), 0);
    end
    sector_in = 3'd5; theta_in = 6'd40; period_in = 12'd33; en = 1;
    @(negedge clk);
    chk(period_strobe == 1, "R2", "re-enable priming strobe", int'(period_strobe), 1);
    chk(gate_hi == 0 && gate_lo == 0, "R2", "re-enable priming gates", int'({gate_hi, gate_lo}), 0);
    wait_strobe();
    measure(5, 40, 33);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule